// File: doc/BRIEF.md
# Byte-Serial SPI Master Shift Engine

This block is the data path of a serial peripheral master. Bytes written into a transmit queue are shifted out most significant bit first on `mosi`, while the same serial clock edges capture `miso` into a receive queue, so every byte sent yields one byte received. The serial clock is derived from the block clock through a power-of-two divider. The clock polarity, the clock phase and the four active-low device-select lines come from a single control word.

Every field of that control word is decoded here. The control word sets the idle level of the serial clock and which edge samples. It sets the divider exponent and the device-select pattern. It also chooses whether the selects track the transfer or are forced from the pattern, and whether shifting starts on its own or waits for a start strobe. A separate run enable and an enable bit inside the word must both be high before any byte is shifted.

Top module: `spi_shift_master`

## Requirements
- R1: After reset `busy` is 0, `ss_n` is all ones, and both `tx_empty` and `rx_empty` are 1.
- R2: Each half period of `sclk` lasts 2^N block-clock cycles, where N is control bits 5:3. N = 0 behaves as N = 1, so the division ranges from 4 to 256.
- R3: While `busy` is 0, `sclk` rests at the polarity bit (control bit 1).
- R4: Bytes leave on `mosi` MSB first. With the phase bit (control bit 2) at 0, the slave samples on the first `sclk` edge of each byte and every second edge after it. With the phase bit at 1, sampling is on the second edge and every second edge after it.
- R5: Every byte shifted out pushes one byte into the receive queue, taken from `miso` MSB first on the sampling edges. The bytes come out of the queue in the order they were shifted.
- R6: With the force bit (control bit 14) at 0, `ss_n` equals the pattern in control bits 13:10 while `busy` is 1 and is all ones while `busy` is 0.
- R7: With the force bit at 1, `ss_n` equals control bits 13:10 at all times, whether or not a transfer runs.
- R8: With manual start (control bit 15) at 0, a transfer starts on its own whenever the transmit queue holds data and the engine is enabled.
- R9: With manual start at 1, queued bytes wait until a one-cycle pulse on control bit 16. After that pulse the engine drains the whole queue.
- R10: The engine runs only while `run_en` and control bit 0 are both 1. While either is low, no transfer starts, and `busy` is 0 one cycle after it drops.
- R11: `busy` rises when a byte is taken from the transmit queue. It stays high without a break across bytes that are already queued, and falls once the last byte has been captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; serial clock reference |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Global engine enable |
| cfg_word | input | 17 | Control word (polarity, phase, divider, selects, force, manual start, start strobe, enable) |
| tx_push | input | 1 | Write `tx_byte` into the transmit queue |
| tx_byte | input | WORD_W | Byte to transmit |
| tx_full | output | 1 | Transmit queue full |
| tx_empty | output | 1 | Transmit queue empty |
| rx_pop | input | 1 | Remove the head of the receive queue |
| rx_byte | output | WORD_W | Head of the receive queue |
| rx_empty | output | 1 | Receive queue empty |
| busy | output | 1 | A transfer is in progress |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 4 | Active-low device selects |

## Verification
Two things can happen in the same clock edge. The engine can pop the transmit queue while the bench pushes into it, and the divider's end-of-byte tick can coincide with the decision to load the next byte. The bench provokes both by pushing a burst of bytes on consecutive cycles: the second push lands on the edge where the engine takes the first byte. A slave model then confirms that every byte appears on `mosi` in order and that `busy` falls only once per burst. The same runs are repeated over all four polarity/phase modes and random divider settings.

// File: rtl/spi_sm_pkg.sv
package spi_sm_pkg;
   // control word layout
   localparam int BIT_EN    = 0;
   localparam int BIT_CPOL  = 1;
   localparam int BIT_CPHA  = 2;
   localparam int DIV_LO    = 3;
   localparam int DIV_W     = 3;
   localparam int SS_LO     = 10;
   localparam int SS_W      = 4;
   localparam int BIT_FORCE = 14;
   localparam int BIT_MAN   = 15;
   localparam int BIT_START = 16;
   localparam int CFG_W     = 17;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_LEAD,
      ST_SHIFT,
      ST_TRAIL
   } eng_state_t;
endpackage

// File: rtl/spi_sm_fifo.sv
module spi_sm_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 128
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] wdata,
   input  logic         pop,
   output logic [W-1:0] rdata,
   output logic         empty,
   output logic         full
);
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam bit POW2 = ((1 << AW) == DEPTH);

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp, wp_nx, rp_nx;
   logic [AW:0]   cnt;
   logic          do_push, do_pop;

   assign empty   = (cnt == '0);
   assign full    = (cnt == (AW+1)'(DEPTH));
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign rdata   = mem[rp];

   generate
      if (POW2) begin : g_wrap_free
         assign wp_nx = wp + 1'b1;
         assign rp_nx = rp + 1'b1;
      end else begin : g_wrap_cmp
         assign wp_nx = (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
         assign rp_nx = (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (do_push) wp <= wp_nx;
         if (do_pop)  rp <= rp_nx;
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end
endmodule

// File: rtl/spi_sm_clkdiv.sv
module spi_sm_clkdiv #(
   parameter int DIV_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             restart,
   input  logic [DIV_W-1:0] div_sel,
   output logic             tick
);
   // largest exponent the field can hold sets the counter width
   localparam int CNT_W = (1 << DIV_W) - 1;

   logic [DIV_W-1:0] eff;
   logic [CNT_W:0]   half_last;
   logic [CNT_W:0]   cnt;

   assign eff       = (div_sel == '0) ? DIV_W'(1) : div_sel;
   assign half_last = ((CNT_W+1)'(1) << eff) - 1'b1;
   assign tick      = run && (cnt == half_last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt <= '0;
      else if (restart || !run)   cnt <= '0;
      else if (tick)              cnt <= '0;
      else                        cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/spi_sm_engine.sv
module spi_sm_engine
   import spi_sm_pkg::*;
#(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         active,
   input  logic         cpol,
   input  logic         cpha,
   input  logic         manual,
   input  logic         start,
   input  logic         tx_avail,
   input  logic [W-1:0] tx_data,
   output logic         tx_pop,
   output logic         rx_push,
   output logic [W-1:0] rx_data,
   input  logic         tick,
   output logic         div_run,
   output logic         div_restart,
   output logic         busy,
   output logic         cs_active,
   output logic         sclk,
   output logic         mosi,
   input  logic         miso
);
   localparam int EDGES = 2 * W;
   localparam int EW    = $clog2(EDGES);

   eng_state_t   state;
   logic [EW-1:0] edge_idx;
   logic [W-1:0]  tx_sr, rx_sr;
   logic          sclk_q, armed;
   logic          decide, go, load;

   assign decide      = (state == ST_IDLE) || (state == ST_TRAIL && tick);
   assign go          = tx_avail && (!manual || armed || start);
   assign load        = active && decide && go;
   assign tx_pop      = load;
   assign rx_push     = active && (state == ST_TRAIL) && tick;
   assign rx_data     = rx_sr;
   assign div_run     = (state != ST_IDLE);
   assign div_restart = load;
   assign busy        = (state != ST_IDLE);
   assign cs_active   = busy;
   assign sclk        = sclk_q;
   assign mosi        = tx_sr[W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    armed <= 1'b0;
      else if (!active || !manual)   armed <= 1'b0;
      else if (start)                armed <= 1'b1;
      else if (decide && !tx_avail)  armed <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         sclk_q   <= 1'b0;
         edge_idx <= '0;
         tx_sr    <= '0;
         rx_sr    <= '0;
      end else if (!active) begin
         state    <= ST_IDLE;
         sclk_q   <= cpol;
         edge_idx <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               sclk_q <= cpol;
               if (load) begin
                  tx_sr    <= tx_data;
                  edge_idx <= '0;
                  state    <= ST_LEAD;
               end
            end
            ST_LEAD: begin
               if (tick) state <= ST_SHIFT;
            end
            ST_SHIFT: begin
               if (tick) begin
                  sclk_q   <= ~sclk_q;
                  edge_idx <= edge_idx + 1'b1;
                  if (edge_idx[0] == cpha)
                     rx_sr <= {rx_sr[W-2:0], miso};
                  else if (edge_idx != '0)
                     tx_sr <= {tx_sr[W-2:0], 1'b0};
                  if (edge_idx == EW'(EDGES-1)) state <= ST_TRAIL;
               end
            end
            default: begin
               if (tick) begin
                  if (load) begin
                     tx_sr    <= tx_data;
                     edge_idx <= '0;
                     state    <= ST_LEAD;
                  end else begin
                     state <= ST_IDLE;
                  end
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/spi_shift_master.sv
module spi_shift_master
   import spi_sm_pkg::*;
#(
   parameter int FIFO_DEPTH = 128,
   parameter int WORD_W     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_en,
   input  logic [16:0]       cfg_word,
   input  logic              tx_push,
   input  logic [WORD_W-1:0] tx_byte,
   output logic              tx_full,
   output logic              tx_empty,
   input  logic              rx_pop,
   output logic [WORD_W-1:0] rx_byte,
   output logic              rx_empty,
   output logic              busy,
   output logic              sclk,
   output logic              mosi,
   input  logic              miso,
   output logic [3:0]        ss_n
);
   generate
      if (WORD_W < 2)     begin : g_bad_word  $error("WORD_W must be at least 2"); end
      if (FIFO_DEPTH < 2) begin : g_bad_depth $error("FIFO_DEPTH must be at least 2"); end
      if (CFG_W != 17)    begin : g_bad_cfg   $error("control word layout mismatch"); end
   endgenerate

   logic              active, tick, div_run, div_restart, cs_active;
   logic              tx_pop, rx_push;
   logic [WORD_W-1:0] tx_head, rx_word;
   logic [SS_W-1:0]   ss_field;
   logic              unused_cfg_bits;

   assign active          = run_en && cfg_word[BIT_EN];
   assign ss_field        = cfg_word[SS_LO +: SS_W];
   assign unused_cfg_bits = ^cfg_word[SS_LO-1:DIV_LO+DIV_W];

   spi_sm_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n),
      .push(tx_push), .wdata(tx_byte),
      .pop(tx_pop), .rdata(tx_head),
      .empty(tx_empty), .full(tx_full)
   );

   logic rx_full_unused;
   spi_sm_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n),
      .push(rx_push), .wdata(rx_word),
      .pop(rx_pop), .rdata(rx_byte),
      .empty(rx_empty), .full(rx_full_unused)
   );

   spi_sm_clkdiv #(.DIV_W(DIV_W)) u_div (
      .clk(clk), .rst_n(rst_n),
      .run(div_run), .restart(div_restart),
      .div_sel(cfg_word[DIV_LO +: DIV_W]),
      .tick(tick)
   );

   spi_sm_engine #(.W(WORD_W)) u_eng (
      .clk(clk), .rst_n(rst_n),
      .active(active),
      .cpol(cfg_word[BIT_CPOL]), .cpha(cfg_word[BIT_CPHA]),
      .manual(cfg_word[BIT_MAN]), .start(cfg_word[BIT_START]),
      .tx_avail(!tx_empty), .tx_data(tx_head), .tx_pop(tx_pop),
      .rx_push(rx_push), .rx_data(rx_word),
      .tick(tick), .div_run(div_run), .div_restart(div_restart),
      .busy(busy), .cs_active(cs_active),
      .sclk(sclk), .mosi(mosi), .miso(miso)
   );

   generate
      for (genvar i = 0; i < SS_W; i++) begin : g_sel
         assign ss_n[i] = (cfg_word[BIT_FORCE] || cs_active) ? ss_field[i] : 1'b1;
      end
   endgenerate
endmodule

// File: rtl/spi_shift_master_chk.sv
module spi_shift_master_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        run_en,
   input logic [16:0] cfg_word,
   input logic        busy,
   input logic        sclk,
   input logic [3:0]  ss_n
);
   // R10: a transfer can only begin after an enabled cycle
   assert_start_enabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(run_en && cfg_word[0]));

   // R10: dropping either enable idles the engine next cycle
   assert_disable_idles_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(run_en && cfg_word[0]) |=> !busy);

   // R6: selects released while idle in tracking mode
   assert_sel_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !cfg_word[14]) |-> (ss_n == 4'hF));

   // R7: forced selects follow the pattern
   assert_sel_forced_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_word[14] |-> (ss_n == cfg_word[13:10]));

   // R3: serial clock rests at the polarity level while idle
   assert_sclk_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && $past(!busy) && $stable(cfg_word[1])) |-> (sclk == cfg_word[1]));
endmodule

bind spi_shift_master spi_shift_master_chk u_chk (
   .clk(clk), .rst_n(rst_n), .run_en(run_en), .cfg_word(cfg_word),
   .busy(busy), .sclk(sclk), .ss_n(ss_n)
);

// File: tb/spi_shift_master_bench.sv
module spi_shift_master_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        run_en = 1'b0;
   logic [16:0] cfg_word = '0;
   logic        tx_push = 1'b0;
   logic [7:0]  tx_byte = '0;
   logic        tx_full, tx_empty, rx_empty, busy, sclk, mosi;
   logic        rx_pop = 1'b0;
   logic [7:0]  rx_byte;
   logic        miso = 1'b0;
   logic [3:0]  ss_n;

   always #4 clk = ~clk;

   spi_shift_master u_spi_shift_master (
      .clk(clk), .rst_n(rst_n), .run_en(run_en), .cfg_word(cfg_word),
      .tx_push(tx_push), .tx_byte(tx_byte), .tx_full(tx_full), .tx_empty(tx_empty),
      .rx_pop(rx_pop), .rx_byte(rx_byte), .rx_empty(rx_empty),
      .busy(busy), .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n)
   );

   int total = 0;
   int bad   = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d", req, act, exp);
      end
   endtask

   function automatic logic [16:0] mk(bit en, bit cpol, bit cpha, int n, logic [3:0] ss,
                                      bit frc, bit man, bit st);
      logic [16:0] c = '0;
      c[0] = en; c[1] = cpol; c[2] = cpha; c[5:3] = 3'(n);
      c[13:10] = ss; c[14] = frc; c[15] = man; c[16] = st;
      return c;
   endfunction

   function automatic logic [7:0] reply(int i);
      return 8'((i * 73 + 29) ^ 8'h5A);
   endfunction

   // slave model state
   int          cyc = 0, ecnt = 0, last_edge = 0, rep_idx = 0;
   int          exp_half = 4, half_bad = 0, ss_bad = 0, busy_falls = 0;
   bit          slv_cpha = 0;
   logic [3:0]  exp_ss = 4'hF;
   logic        prev_sclk = 1'b0, prev_busy = 1'b0;
   logic [7:0]  cur, cap;
   logic [7:0]  txq[$], capq[$], repq[$];

   always @(negedge clk) begin
      automatic int k;
      cyc++;
      if (busy && ss_n !== exp_ss) ss_bad++;
      if (prev_busy && !busy) busy_falls++;
      prev_busy = busy;
      if (sclk !== prev_sclk && busy) begin
         k = ecnt % 16;
         if (k != 0 && (cyc - last_edge) != exp_half) half_bad++;
         last_edge = cyc;
         if (k[0] == slv_cpha) cap = {cap[6:0], mosi};
         else if (!slv_cpha && k < 15) miso = cur[7 - (k + 1) / 2];
         else if (slv_cpha) miso = cur[7 - k / 2];
         if (k == 15) begin
            capq.push_back(cap);
            repq.push_back(cur);
            rep_idx++;
            cur = reply(rep_idx);
            if (!slv_cpha) miso = cur[7];
         end
         ecnt++;
      end
      prev_sclk = sclk;
   end

   task automatic prep(bit cpha, int n, logic [3:0] ss);
      slv_cpha = cpha;
      exp_half = 1 << ((n == 0) ? 1 : n);
      exp_ss = ss;
      half_bad = 0; ss_bad = 0; busy_falls = 0;
      txq.delete(); capq.delete(); repq.delete();
      cur = reply(rep_idx);
      if (!cpha) miso = cur[7];
   endtask

   task automatic push_burst(int nb);
      for (int i = 0; i < nb; i++) begin
         logic [7:0] b = 8'($urandom);
         tx_byte = b; tx_push = 1'b1; txq.push_back(b);
         @(negedge clk);
      end
      tx_push = 1'b0;
   endtask

   task automatic wait_done();
      @(negedge clk);
      while (!(tx_empty && !busy)) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   task automatic judge(int nb, bit cpol, int falls_exp);
      chk(capq.size() == nb, "R4 byte count", capq.size(), nb);
      for (int i = 0; i < nb && i < capq.size(); i++)
         chk(capq[i] == txq[i], "R4 mosi byte", capq[i], txq[i]);
      for (int i = 0; i < nb && i < repq.size(); i++) begin
         chk(!rx_empty, "R5 rx present", rx_empty, 0);
         chk(rx_byte == repq[i], "R5 rx byte", rx_byte, repq[i]);
         rx_pop = 1'b1; @(negedge clk); rx_pop = 1'b0;
      end
      chk(rx_empty, "R5 rx drained", rx_empty, 1);
      chk(half_bad == 0, "R2 half period", half_bad, 0);
      chk(ss_bad == 0, "R6 select during transfer", ss_bad, 0);
      chk(busy_falls == falls_exp, "R11 busy continuity", busy_falls, falls_exp);
      chk(sclk == cpol, "R3 idle sclk", sclk, cpol);
   endtask

   task automatic run_auto(bit cpol, bit cpha, int n, int nb, logic [3:0] ss);
      cfg_word = mk(1, cpol, cpha, n, ss, 0, 0, 0);
      run_en = 1'b1;
      repeat (3) @(negedge clk);
      prep(cpha, n, ss);
      push_burst(nb);
      wait_done();
      judge(nb, cpol, 1);
      chk(ss_n == 4'hF, "R6 idle select", ss_n, 15);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED));
      repeat (5) @(negedge clk);
      chk(busy == 0, "R1 busy", busy, 0);
      chk(ss_n == 4'hF, "R1 ss_n", ss_n, 15);
      chk(tx_empty && rx_empty, "R1 queues empty", {tx_empty, rx_empty}, 3);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R8 auto start, all four modes with random dividers, R4 R5
      for (int m = 0; m < 4; m++)
         for (int r = 0; r < 2; r++)
            run_auto(m[1], m[0], $urandom_range(1, 4), $urandom_range(1, 5),
                     4'hF & ~(4'h1 << $urandom_range(0, 3)));

      // R2 corner dividers: N=0 acts as 1, N=7 is the slowest
      run_auto(0, 0, 0, 2, 4'hE);
      run_auto(1, 1, 7, 1, 4'h7);

      // R10 engine held off by run_en and by control enable
      cfg_word = mk(1, 0, 1, 2, 4'hD, 0, 0, 0);
      run_en = 1'b0;
      prep(1, 2, 4'hD);
      push_burst(1);
      repeat (60) @(negedge clk);
      chk(!busy && !tx_empty, "R10 run_en low holds", busy, 0);
      run_en = 1'b1;
      cfg_word = mk(0, 0, 1, 2, 4'hD, 0, 0, 0);
      repeat (60) @(negedge clk);
      chk(!busy && capq.size() == 0, "R10 enable bit low holds", capq.size(), 0);
      cfg_word = mk(1, 0, 1, 2, 4'hD, 0, 0, 0);
      wait_done();
      judge(1, 0, 1);

      // R9 manual start
      cfg_word = mk(1, 1, 0, 1, 4'hB, 0, 1, 0);
      repeat (3) @(negedge clk);
      prep(0, 1, 4'hB);
      push_burst(3);
      repeat (60) @(negedge clk);
      chk(!busy && !tx_empty, "R9 waits for strobe", busy, 0);
      chk(ss_n == 4'hF, "R9 selects idle", ss_n, 15);
      cfg_word = mk(1, 1, 0, 1, 4'hB, 0, 1, 1);
      @(negedge clk);
      cfg_word = mk(1, 1, 0, 1, 4'hB, 0, 1, 0);
      wait_done();
      judge(3, 1, 1);

      // R7 forced selects, idle and during a transfer
      cfg_word = mk(1, 0, 0, 2, 4'h6, 1, 0, 0);
      repeat (3) @(negedge clk);
      chk(ss_n == 4'h6, "R7 forced idle", ss_n, 6);
      prep(0, 2, 4'h6);
      push_burst(2);
      wait_done();
      judge(2, 0, 1);
      chk(ss_n == 4'h6, "R7 forced after", ss_n, 6);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule